// File: doc/BRIEF.md
# Supervisor Reset and Watchdog Timer

This block is the digital core of a processor supervisor. It drives an active-high reset, an active-low reset and an active-low watchdog-fault output. Its inputs are flags that analog circuitry produces elsewhere: a supply-low flag from a threshold comparator, a battery-mode flag, and a flag that marks the watchdog strobe as left floating. The strobe itself is a plain digital input that the supervised processor toggles to show that it is alive.

The block holds reset for a full reset timeout after the supply recovers. It watches the strobe for edges of either polarity. If no edge arrives within the watchdog window, it fires a reset pulse and latches a fault indication. That indication clears on the next strobe edge. The first window after any reset, and after any re-enable, is a long one. Later windows use the normal length. When the `ext_clk_mode` pin is high, every period counts raw clock cycles. Otherwise the periods are counted in milliseconds, one tick every `CLK_PER_MS` cycles, and the `fast_wdog` pin shortens the normal window.

The controller has four states. `S_HOLD` means the supply is low. `S_RST` times the reset pulse. `S_WATCH` times the watchdog window. `S_OFF` means the watchdog is disabled and reset is released. Its transitions are named as follows:
- supply-drop: any state goes to `S_HOLD` while supply-low is set.
- recover: `S_HOLD` goes to `S_RST` once supply-low clears.
- release: `S_RST` goes to `S_WATCH` when the reset timeout expires with the watchdog enabled.
- park: `S_RST` goes to `S_OFF` when the reset timeout expires with the watchdog disabled.
- kick: `S_WATCH` stays in `S_WATCH` and restarts on a strobe edge, now using the normal window.
- bite: `S_WATCH` goes to `S_RST` when the window expires with no edge.
- disable: `S_WATCH` goes to `S_OFF`.
- resume: `S_OFF` goes to `S_WATCH` with the long window.

Top module: `sup_rst_wdt`

## Requirements
- R1: While `arst_n` is low, `rst_out` is 1, `rst_out_n` is 0 and `wdog_fault_n` is 1. The first clock edge after release starts the reset timeout.
- R2: `rst_out` goes to 1 and `rst_out_n` goes to 0 in the same cycle that `supply_low` becomes 1, with no clock edge in between.
- R3: After `supply_low` returns to 0, reset stays asserted for one more cycle, then for the full reset timeout: 2048 cycles when `ext_clk_mode`=1, or 200 ms (200·`CLK_PER_MS` cycles) otherwise.
- R4: When `ext_clk_mode`=1, the watchdog window is 4096 cycles after a reset and 1024 cycles after a strobe edge.
- R5: When `ext_clk_mode`=0, the window after a reset is 1600 ms. The window after a strobe edge is 100 ms if `fast_wdog`=1 and 1600 ms if `fast_wdog`=0.
- R6: Both rising and falling strobe edges restart the window. The strobe passes through two synchronizing flops, so a change driven after clock edge 0 restarts the count at edge 3. A pulse one clock cycle wide yields two restarts.
- R7: When the window expires with no edge, the same clock edge asserts reset for one reset timeout and drives `wdog_fault_n` to 0.
- R8: `wdog_fault_n` stays 0 until the first synchronized strobe edge, and it returns to 1 at that edge (edge 3 after the change), even while the reset pulse is still running.
- R9: With the strobe held constant, the outputs repeat a pattern: a reset pulse of one reset timeout, then one long window with reset released, then another pulse.
- R10: While `supply_low`, `batt_mode` or `strobe_float` is 1, `wdog_fault_n` reads 1 and no watchdog expiry occurs.
- R11: When the watchdog is re-enabled, the window restarts from the long post-reset length. Counting from the cycle in which the disabling flag clears, the next expiry comes 1 + long-window cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous power-on reset of the block's flops, active low |
| supply_low | input | 1 | Supply below reset threshold, from an external comparator |
| batt_mode | input | 1 | System running from the backup source |
| strobe_float | input | 1 | Strobe input detected as left open |
| strobe | input | 1 | Watchdog strobe from the processor, asynchronous |
| ext_clk_mode | input | 1 | 1: periods in clock cycles; 0: periods in millisecond ticks |
| fast_wdog | input | 1 | Internal timebase only: selects the short normal window |
| rst_out | output | 1 | Reset, active high |
| rst_out_n | output | 1 | Reset, active low |
| wdog_fault_n | output | 1 | Watchdog fault, active low |

## Verification
The reset outputs respond to `supply_low` in the same cycle. Every other result is due on a clock edge: a state change takes one edge, and a strobe change takes effect three edges after it is driven. The bench drives inputs just after a rising edge and compares all three outputs with its behavioural model at every falling edge. The model advances on the same rising edges and keeps its own three-deep strobe history. Pulse and window lengths are measured by counting falling-edge samples, starting from a stated cycle, and compared with the cycle totals from R3 to R11. These totals include the extra cycle in `S_HOLD` and the three-edge strobe latency.

// File: rtl/sup_pkg.sv
package sup_pkg;
    typedef enum logic [1:0] {
        S_HOLD  = 2'd0,
        S_RST   = 2'd1,
        S_WATCH = 2'd2,
        S_OFF   = 2'd3
    } sup_state_t;
endpackage

// File: rtl/sup_sync.sv
module sup_sync (
    input  logic clk,
    input  logic arst_n,
    input  logic din,
    output logic edge_p
);
    logic [2:0] stg;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) stg <= 3'b000;
        else         stg <= {stg[1:0], din};
    end

    assign edge_p = stg[1] ^ stg[2];
endmodule

// File: rtl/sup_tick.sv
module sup_tick #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic arst_n,
    input  logic clr,
    input  logic ext_mode,
    output logic tick
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] pre;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n)          pre <= '0;
        else if (clr)         pre <= '0;
        else if (pre == LAST) pre <= '0;
        else                  pre <= pre + PW'(1);
    end

    assign tick = ext_mode | (pre == LAST);
endmodule

// File: rtl/sup_rst_wdt.sv
module sup_rst_wdt
    import sup_pkg::*;
#(
    parameter int CLK_PER_MS     = 200000,
    parameter int EXT_RST        = 2048,
    parameter int EXT_WD         = 1024,
    parameter int EXT_WD_LONG    = 4096,
    parameter int INT_RST_MS     = 200,
    parameter int INT_WD_FAST_MS = 100,
    parameter int INT_WD_SLOW_MS = 1600,
    parameter int INT_WD_LONG_MS = 1600
) (
    input  logic clk,
    input  logic arst_n,
    input  logic supply_low,
    input  logic batt_mode,
    input  logic strobe_float,
    input  logic strobe,
    input  logic ext_clk_mode,
    input  logic fast_wdog,
    output logic rst_out,
    output logic rst_out_n,
    output logic wdog_fault_n
);
    localparam int M1 = (EXT_RST > EXT_WD) ? EXT_RST : EXT_WD;
    localparam int M2 = (M1 > EXT_WD_LONG) ? M1 : EXT_WD_LONG;
    localparam int M3 = (M2 > INT_RST_MS) ? M2 : INT_RST_MS;
    localparam int M4 = (M3 > INT_WD_FAST_MS) ? M3 : INT_WD_FAST_MS;
    localparam int M5 = (M4 > INT_WD_SLOW_MS) ? M4 : INT_WD_SLOW_MS;
    localparam int LIM_MAX = (M5 > INT_WD_LONG_MS) ? M5 : INT_WD_LONG_MS;
    localparam int CW = $clog2(LIM_MAX + 1);

    sup_state_t    state, nxt;
    logic [CW-1:0] cnt, rst_lim, wd_lim, cur_lim;
    logic          first_q, fault_q;
    logic          tick, sync_edge, wd_dis, expire, restart;

    assign wd_dis = batt_mode | strobe_float;

    sup_sync u_sync (
        .clk    (clk),
        .arst_n (arst_n),
        .din    (strobe),
        .edge_p (sync_edge)
    );

    sup_tick #(.DIV(CLK_PER_MS)) u_tick (
        .clk      (clk),
        .arst_n   (arst_n),
        .clr      (restart),
        .ext_mode (ext_clk_mode),
        .tick     (tick)
    );

    // period selection
    always_comb begin
        rst_lim = ext_clk_mode ? CW'(EXT_RST) : CW'(INT_RST_MS);
        if (ext_clk_mode)   wd_lim = first_q ? CW'(EXT_WD_LONG) : CW'(EXT_WD);
        else if (first_q)   wd_lim = CW'(INT_WD_LONG_MS);
        else                wd_lim = fast_wdog ? CW'(INT_WD_FAST_MS) : CW'(INT_WD_SLOW_MS);
        cur_lim = (state == S_RST) ? rst_lim : wd_lim;
    end

    assign expire = tick & (cnt == cur_lim - CW'(1));

    // next state
    always_comb begin
        nxt = state;
        if (supply_low) begin
            nxt = S_HOLD;
        end else begin
            unique case (state)
                S_HOLD:  nxt = S_RST;
                S_RST:   if (expire) nxt = wd_dis ? S_OFF : S_WATCH;
                S_WATCH: begin
                    if (wd_dis)                    nxt = S_OFF;
                    else if (!sync_edge && expire) nxt = S_RST;
                end
                S_OFF:   if (!wd_dis) nxt = S_WATCH;
            endcase
        end
    end

    assign restart = (nxt != state) |
                     ((state == S_WATCH) & (nxt == S_WATCH) & sync_edge);

    // state register
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) state <= S_HOLD;
        else         state <= nxt;
    end

    // period counter, window length and fault latch
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            cnt     <= '0;
            first_q <= 1'b1;
            fault_q <= 1'b0;
        end else begin
            if (restart)
                cnt <= '0;
            else if (tick && (state == S_RST || state == S_WATCH))
                cnt <= cnt + CW'(1);

            if (state != S_WATCH && nxt == S_WATCH)
                first_q <= 1'b1;
            else if (state == S_WATCH && nxt == S_WATCH && restart)
                first_q <= 1'b0;

            if (supply_low || wd_dis || sync_edge)
                fault_q <= 1'b0;
            else if (state == S_WATCH && nxt == S_RST)
                fault_q <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        rst_out      = supply_low | (state == S_HOLD) | (state == S_RST);
        rst_out_n    = ~rst_out;
        wdog_fault_n = ~(fault_q & ~wd_dis & ~supply_low);
    end

    // R2: a low supply lands the controller in the hold state
    a_r2_hold_on_low: assert property (@(posedge clk) disable iff (!arst_n)
        supply_low |=> (state == S_HOLD));

    // R3: the reset pulse ends exactly when its period runs out
    a_r3_rst_ends: assert property (@(posedge clk) disable iff (!arst_n)
        (state == S_RST && !supply_low && tick && cnt == rst_lim - CW'(1)) |=> (state != S_RST));

    // R7: an unkicked expiry starts a reset pulse and latches the fault
    a_r7_bite: assert property (@(posedge clk) disable iff (!arst_n)
        (state == S_WATCH && !supply_low && !wd_dis && !sync_edge && expire)
        |=> (state == S_RST && fault_q));

    // R8: a synchronized strobe edge clears the fault
    a_r8_kick_clears: assert property (@(posedge clk) disable iff (!arst_n)
        sync_edge |=> !fault_q);

    // R10: a disabled watchdog never holds a fault
    a_r10_dis_no_fault: assert property (@(posedge clk) disable iff (!arst_n)
        (wd_dis || supply_low) |=> !fault_q);

    // R11: re-enabling resumes with the long window
    a_r11_resume_long: assert property (@(posedge clk) disable iff (!arst_n)
        (state == S_OFF && !wd_dis && !supply_low) |=> (state == S_WATCH && first_q));
endmodule

// File: tb/tb_sup_rst_wdt.sv
`timescale 1ns/1ps
module tb_sup_rst_wdt;
    localparam int DIV = 4;

    logic clk = 1'b0;
    logic arst_n = 1'b0;
    logic supply_low = 1'b0, batt_mode = 1'b0, strobe_float = 1'b0, strobe = 1'b0;
    logic ext_clk_mode = 1'b1, fast_wdog = 1'b0;
    logic rst_out, rst_out_n, wdog_fault_n;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    sup_rst_wdt #(.CLK_PER_MS(DIV)) dut (
        .clk(clk), .arst_n(arst_n), .supply_low(supply_low), .batt_mode(batt_mode),
        .strobe_float(strobe_float), .strobe(strobe), .ext_clk_mode(ext_clk_mode),
        .fast_wdog(fast_wdog), .rst_out(rst_out), .rst_out_n(rst_out_n),
        .wdog_fault_n(wdog_fault_n)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_st = 0;      // 0 hold, 1 reset pulse, 2 window, 3 off
    int m_left = 0;    // cycles remaining in the current period
    bit m_first = 1, m_fault = 0;
    bit hist[$] = '{0, 0, 0};

    function automatic int rst_cyc();
        return ext_clk_mode ? 2048 : 200 * DIV;
    endfunction
    function automatic int long_cyc();
        return ext_clk_mode ? 4096 : 1600 * DIV;
    endfunction
    function automatic int norm_cyc();
        if (ext_clk_mode) return 1024;
        return fast_wdog ? 100 * DIV : 1600 * DIV;
    endfunction

    always @(posedge clk) begin
        if (!arst_n) begin
            m_st = 0; m_left = 0; m_first = 1; m_fault = 0;
            hist = '{0, 0, 0};
        end else begin
            bit kick, dis;
            kick = hist[1] ^ hist[2];
            dis  = batt_mode | strobe_float;
            hist.push_front(strobe);
            void'(hist.pop_back());
            if (supply_low) begin
                m_st = 0;
            end else begin
                case (m_st)
                    0: begin m_st = 1; m_left = rst_cyc(); end
                    1: begin
                        if (m_left == 1) begin
                            if (dis) m_st = 3;
                            else begin m_st = 2; m_first = 1; m_left = long_cyc(); end
                        end else m_left--;
                    end
                    2: begin
                        if (dis) m_st = 3;
                        else if (kick) begin m_first = 0; m_left = norm_cyc(); end
                        else if (m_left == 1) begin m_st = 1; m_left = rst_cyc(); m_fault = 1; end
                        else m_left--;
                    end
                    default: if (!dis) begin m_st = 2; m_first = 1; m_left = long_cyc(); end
                endcase
            end
            if (supply_low || dis || kick) m_fault = 0;
        end
    end

    always @(negedge clk) begin
        if (arst_n && !done) begin
            bit m_rst, m_fn;
            m_rst = supply_low || (m_st <= 1);
            m_fn  = !(m_fault && !supply_low && !batt_mode && !strobe_float);
            chk(rst_out === m_rst, "R3/R7 model rst_out", rst_out, m_rst);
            chk(rst_out_n === !m_rst, "R2 model rst_out_n", rst_out_n, !m_rst);
            chk(wdog_fault_n === m_fn, "R8 model wdog_fault_n", wdog_fault_n, m_fn);
        end
    end

    // ---------------- helpers ----------------
    task automatic count_level(input logic lvl, input bit incl_now, input int cap, output int n);
        n = (incl_now && rst_out === lvl) ? 1 : 0;
        while (n < cap) begin
            @(negedge clk);
            if (rst_out !== lvl) break;
            n++;
        end
    endtask

    task automatic toggle_strobe();
        @(posedge clk); #1 strobe = ~strobe;
    endtask

    task automatic pulse_strobe();
        @(posedge clk); #1 strobe = ~strobe;
        @(posedge clk); #1 strobe = ~strobe;
    endtask

    task automatic wait_rst_low();
        while (rst_out === 1'b1) @(negedge clk);
    endtask

    task automatic do_arst(input logic ext, input logic fast);
        @(posedge clk); #1 arst_n = 1'b0; ext_clk_mode = ext; fast_wdog = fast;
        repeat (3) @(posedge clk);
        #1 arst_n = 1'b1;
        @(posedge clk);
    endtask

    task automatic finish_run();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        finish_run();
    end

    initial begin
        int n;
        // R1: reset values
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk(rst_out === 1'b1, "R1 rst_out in reset", rst_out, 1);
        chk(rst_out_n === 1'b0, "R1 rst_out_n in reset", rst_out_n, 0);
        chk(wdog_fault_n === 1'b1, "R1 fault_n in reset", wdog_fault_n, 1);
        @(posedge clk); #1 arst_n = 1'b1;
        @(posedge clk);

        // R3/R4/R9: external cycle timebase, constant strobe
        count_level(1'b1, 0, 20000, n); chk(n == 2048, "R3 ext reset length", n, 2048);
        count_level(1'b0, 1, 20000, n); chk(n == 4096, "R4 ext long window", n, 4096);
        chk(wdog_fault_n === 1'b0, "R7 fault low on expiry", wdog_fault_n, 0);
        count_level(1'b1, 1, 20000, n); chk(n == 2048, "R9 repeated pulse", n, 2048);
        count_level(1'b0, 1, 20000, n); chk(n == 4096, "R9 repeated long window", n, 4096);

        // R8: fault clears at the third edge after a strobe change, during the pulse
        toggle_strobe();
        @(negedge clk); @(negedge clk); @(negedge clk);
        chk(wdog_fault_n === 1'b0, "R8 fault still low at edge 2", wdog_fault_n, 0);
        @(negedge clk);
        chk(wdog_fault_n === 1'b1, "R8 fault high at edge 3", wdog_fault_n, 1);
        wait_rst_low();

        // R6: kicks keep reset away; both edges of a one-cycle pulse restart
        for (int i = 0; i < 6; i++) begin
            repeat (500) @(posedge clk);
            pulse_strobe();
            chk(rst_out === 1'b0, "R6 kicked watchdog holds off reset", rst_out, 0);
        end
        count_level(1'b0, 0, 20000, n); chk(n == 1027, "R4 R6 normal window after pulse", n, 1027);

        // R2/R3: supply drop
        wait_rst_low();
        toggle_strobe();
        repeat (10) @(posedge clk);
        #1 supply_low = 1'b1;
        @(negedge clk);
        chk(rst_out === 1'b1, "R2 immediate rst_out", rst_out, 1);
        chk(rst_out_n === 1'b0, "R2 immediate rst_out_n", rst_out_n, 0);
        repeat (10) @(posedge clk);
        #1 supply_low = 1'b0;
        count_level(1'b1, 0, 20000, n); chk(n == 2049, "R3 hold-off after supply recovers", n, 2049);

        // R10/R11: battery mode disables, re-enable uses long window
        @(posedge clk); #1 batt_mode = 1'b1;
        count_level(1'b0, 0, 9000, n); chk(n == 9000, "R10 no expiry in battery mode", n, 9000);
        chk(wdog_fault_n === 1'b1, "R10 fault high in battery mode", wdog_fault_n, 1);
        @(posedge clk); #1 batt_mode = 1'b0;
        count_level(1'b0, 0, 20000, n); chk(n == 4097, "R11 long window after re-enable", n, 4097);
        @(posedge clk); #1 strobe_float = 1'b1;
        @(negedge clk);
        chk(wdog_fault_n === 1'b1, "R10 floating strobe masks fault", wdog_fault_n, 1);
        repeat (3000) @(posedge clk);
        @(negedge clk);
        chk(rst_out === 1'b0, "R10 reset released with watchdog off", rst_out, 0);
        @(posedge clk); #1 strobe_float = 1'b0;
        repeat (100) @(posedge clk);

        // R5: millisecond timebase, fast option
        do_arst(1'b0, 1'b1);
        count_level(1'b1, 0, 20000, n); chk(n == 800, "R5 ms reset length", n, 800);
        count_level(1'b0, 1, 20000, n); chk(n == 6400, "R5 fast long window", n, 6400);
        count_level(1'b1, 1, 20000, n); chk(n == 800, "R5 ms repeated pulse", n, 800);
        wait_rst_low();
        pulse_strobe();
        count_level(1'b0, 0, 20000, n); chk(n == 403, "R5 fast normal window", n, 403);

        // R5: millisecond timebase, default option
        do_arst(1'b0, 1'b0);
        count_level(1'b1, 0, 20000, n); chk(n == 800, "R5 default reset length", n, 800);
        count_level(1'b0, 1, 20000, n); chk(n == 6400, "R5 default long window", n, 6400);
        wait_rst_low();
        toggle_strobe();
        count_level(1'b0, 0, 20000, n); chk(n == 6403, "R5 R6 default normal window", n, 6403);

        finish_run();
    end
endmodule